// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Slave

This block lets an external host processor reach a chip's internal registers through a parallel, asynchronous bus. Two strobe pins are read in one of two ways, set by a static strap. In strobe-pair mode, the pins are an active-low read strobe and an active-low write strobe. In enable/direction mode, the pins are an active-high enable and a direction level, where high means read. An active-low chip select gates every transfer. A register-select pin marks each transfer as a command (high) or as display data (low). A width strap picks between 8-bit transfers on the low byte lane and 16-bit transfers, where the upper lane carries the most significant byte.

All host pins, including the data bus, pass through a reset-initialised synchronizer into the internal clock domain. A transfer state machine (`hbi_xfer_fsm`) tracks each strobe phase and handles the internal side:

- For each cleanly completed write phase, it raises a one-cycle write request. The request carries the tag and data captured in the last sample before the strobe was released.
- For each completed read phase, it raises a one-cycle read-done pulse carrying the tag.

The bus output enables come straight from the pins, without going through the synchronizer, so read data reaches the bus as soon as the host asks for it.

The state machine has five states:

- IDLE: no phase is open.
- WRITE: a write phase is open; tag and data are captured every cycle.
- WPOST: the write is committed and the request is raised.
- READ: a read phase is open.
- RPOST: the read is finished and read-done is raised.

Its transitions are:

- IDLE/WPOST/RPOST go to WRITE on `write-open`, or to READ on `read-open`; otherwise they go to IDLE.
- WRITE stays in WRITE on `write-hold`. It goes to WPOST on `write-release`. It goes to IDLE on `write-abort`, which covers chip select dropping or the direction changing before release.
- READ stays in READ on `read-hold`. It goes to RPOST on `read-release`, which requires chip select still low. Otherwise it goes to IDLE on `read-abort`.

Top module: `host_bus_if`

## Requirements
- R1: In strobe-pair mode (`proto_m68`=0), `bus_oe_lo` is 1 exactly while `cs_n`=0, `strb_a`=0 and `strb_b`=1; otherwise it is 0.
- R2: In enable/direction mode (`proto_m68`=1), `bus_oe_lo` is 1 exactly while `cs_n`=0, `strb_a`=1 and `strb_b`=1; otherwise it is 0.
- R3: In strobe-pair mode, each low-to-high transition of `strb_b` that ends a write phase held with `cs_n`=0 yields exactly one `wr_valid` pulse.
- R4: In enable/direction mode, each high-to-low transition of `strb_a` while `strb_b`=0, ending a write phase held with `cs_n`=0, yields exactly one `wr_valid` pulse.
- R5: No write request and no output enable occur while `cs_n`=1. If `cs_n` rises before the write strobe is released, the write is dropped.
- R6: `wr_cmd` equals the `rs` level of the write phase: 1 marks a command, 0 marks display data.
- R7: With `wide_mode`=1, `wr_data[15:0]` equals `bus_in[15:0]`. During a read, `bus_oe_hi` and `bus_oe_lo` are both 1 and `bus_out` equals `rd_data`.
- R8: With `wide_mode`=0, `wr_data[15:8]` is 0 and `wr_data[7:0]` equals `bus_in[7:0]`. `bus_oe_hi` stays 0 and `bus_out[7:0]` carries `rd_data[7:0]`.
- R9: Each read phase that ends with `cs_n` still 0 yields exactly one `rd_done` pulse, with `rd_cmd` equal to the `rs` level of that read.
- R10: In enable/direction mode, if `strb_b` goes high while `strb_a` is still high in a write phase, no write request is issued.
- R11: After reset, `wr_valid`, `rd_done`, `bus_oe_lo` and `bus_oe_hi` are 0.
- R12: `wr_valid` lasts one cycle. It is high in the cycle after SYNC_STAGES+1 rising clock edges following the strobe release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_m68 | input | 1 | Static protocol strap: 0 strobe pair, 1 enable/direction |
| wide_mode | input | 1 | 1 selects 16-bit transfers |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 1 command, 0 display data |
| strb_a | input | 1 | Read strobe (low active) or enable (high active) |
| strb_b | input | 1 | Write strobe (low active) or direction (1 read) |
| bus_in | input | 16 | Data bus input lanes |
| bus_out | output | 16 | Data bus output lanes |
| bus_oe_lo | output | 1 | Drive enable for lanes 7:0 |
| bus_oe_hi | output | 1 | Drive enable for lanes 15:8 |
| wr_valid | output | 1 | One-cycle write request |
| wr_cmd | output | 1 | Tag of the write request |
| wr_data | output | 16 | Data of the write request |
| rd_data | input | 16 | Read data from the internal side |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_cmd | output | 1 | Tag of the completed read |

## Verification
The assertions take two things for granted:

- The protocol strap only changes while reset is held.
- The host keeps `rs` and the data lanes steady for the whole strobe phase, so the last synchronized sample before release is the intended value.

The stimulus follows both rules. Every pin change is made on a falling clock edge, each phase is held for several cycles, and chip select and direction are changed in cycles separate from the strobe edges. The one exception is the deliberate direction flip used for R10.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_WPOST = 3'd2,
        ST_READ  = 3'd3,
        ST_RPOST = 3'd4
    } hbi_state_t;

    typedef struct packed {
        logic sel;       // chip selected
        logic wr_on;     // write phase open
        logic rd_on;     // read phase open
        logic wr_clean;  // write strobe released in the legal way
        logic rd_clean;  // read strobe released in the legal way
    } hbi_phase_t;

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int              W        = 4,
    parameter int              STAGES   = 2,
    parameter logic [W-1:0]    RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
    import hbi_pkg::*;
(
    input  logic       proto_m68,
    input  logic       cs_n,
    input  logic       pin_a,
    input  logic       pin_b,
    output hbi_phase_t ph
);

    always_comb begin
        ph.sel = ~cs_n;
        if (proto_m68) begin
            // enable high active, direction 1 = read
            ph.wr_on    = pin_a & ~pin_b;
            ph.rd_on    = pin_a &  pin_b;
            ph.wr_clean = ~pin_a & ~pin_b;
            ph.rd_clean = ~pin_a;
        end else begin
            // separate low-active strobes, write wins when both low
            ph.wr_on    = ~pin_b;
            ph.rd_on    = ~pin_a & pin_b;
            ph.wr_clean = pin_b;
            ph.rd_clean = pin_a;
        end
    end

endmodule

// File: rtl/hbi_oe_ctl.sv
module hbi_oe_ctl #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proto_m68,
    input  logic              wide_mode,
    input  logic              cs_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic [2*LANE_W-1:0] rd_data,
    output logic [2*LANE_W-1:0] bus_out,
    output logic              oe_lo,
    output logic              oe_hi
);

    logic read_req;

    always_comb begin
        if (proto_m68) read_req = pin_a & pin_b;
        else           read_req = ~pin_a & pin_b;
        oe_lo   = ~cs_n & read_req;
        oe_hi   = oe_lo & wide_mode;
        bus_out = rd_data;
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lo |-> !cs_n); // R5
    AST_HI_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi |-> (wide_mode && oe_lo)); // R8
    AST_PROTO_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(proto_m68)); // R2

endmodule

// File: rtl/hbi_xfer_fsm.sv
module hbi_xfer_fsm
    import hbi_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  hbi_phase_t          ph,
    input  logic                rs_s,
    input  logic [2*LANE_W-1:0] data_s,
    input  logic                wide_mode,
    output logic                wr_valid,
    output logic                wr_cmd,
    output logic [2*LANE_W-1:0] wr_data,
    output logic                rd_done,
    output logic                rd_cmd
);

    localparam int BUS_W = 2 * LANE_W;

    hbi_state_t state, state_nx;
    logic [BUS_W-1:0] data_q;
    logic             wtag_q;
    logic             rtag_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_WPOST, ST_RPOST: begin
                if (ph.sel && ph.wr_on)      state_nx = ST_WRITE;   // write-open
                else if (ph.sel && ph.rd_on) state_nx = ST_READ;    // read-open
                else                         state_nx = ST_IDLE;
            end
            ST_WRITE: begin
                if (!ph.sel)          state_nx = ST_IDLE;           // write-abort
                else if (ph.wr_on)    state_nx = ST_WRITE;          // write-hold
                else if (ph.wr_clean) state_nx = ST_WPOST;          // write-release
                else                  state_nx = ST_IDLE;           // write-abort
            end
            ST_READ: begin
                if (ph.sel && ph.rd_on)         state_nx = ST_READ;  // read-hold
                else if (ph.sel && ph.rd_clean) state_nx = ST_RPOST; // read-release
                else                            state_nx = ST_IDLE;  // read-abort
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // capture registers: last sample of an open phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            wtag_q <= 1'b0;
            rtag_q <= 1'b0;
        end else begin
            if (state_nx == ST_WRITE) begin
                wtag_q <= rs_s;
                if (wide_mode) data_q <= data_s;
                else           data_q <= {{LANE_W{1'b0}}, data_s[LANE_W-1:0]};
            end
            if (state_nx == ST_READ) rtag_q <= rs_s;
        end
    end

    // outputs
    always_comb begin
        wr_valid = (state == ST_WPOST);
        rd_done  = (state == ST_RPOST);
        wr_cmd   = wtag_q;
        wr_data  = data_q;
        rd_cmd   = rtag_q;
    end

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R12
    AST_WR_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(ph.sel)); // R5
    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_done)); // R9
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wide_mode) |-> (wr_data[BUS_W-1:LANE_W] == '0)); // R8
    AST_RD_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(ph.sel)); // R9

endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
    import hbi_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                proto_m68,
    input  logic                wide_mode,
    input  logic                cs_n,
    input  logic                rs,
    input  logic                strb_a,
    input  logic                strb_b,
    input  logic [2*LANE_W-1:0] bus_in,
    output logic [2*LANE_W-1:0] bus_out,
    output logic                bus_oe_lo,
    output logic                bus_oe_hi,
    output logic                wr_valid,
    output logic                wr_cmd,
    output logic [2*LANE_W-1:0] wr_data,
    input  logic [2*LANE_W-1:0] rd_data,
    output logic                rd_done,
    output logic                rd_cmd
);

    localparam int BUS_W  = 2 * LANE_W;
    localparam int SYNC_W = BUS_W + 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

    logic [SYNC_W-1:0] pins_raw, pins_s;
    logic              cs_n_s, rs_s, a_s, b_s;
    logic [BUS_W-1:0]  data_s;
    hbi_phase_t        ph_s;

    assign pins_raw = {cs_n, rs, strb_a, strb_b, bus_in};
    assign {cs_n_s, rs_s, a_s, b_s, data_s} = pins_s;

    hbi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hbi_decode u_dec (
        .proto_m68 (proto_m68),
        .cs_n      (cs_n_s),
        .pin_a     (a_s),
        .pin_b     (b_s),
        .ph        (ph_s)
    );

    hbi_xfer_fsm #(.LANE_W(LANE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph_s),
        .rs_s      (rs_s),
        .data_s    (data_s),
        .wide_mode (wide_mode),
        .wr_valid  (wr_valid),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .rd_done   (rd_done),
        .rd_cmd    (rd_cmd)
    );

    hbi_oe_ctl #(.LANE_W(LANE_W)) u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .proto_m68 (proto_m68),
        .wide_mode (wide_mode),
        .cs_n      (cs_n),
        .pin_a     (strb_a),
        .pin_b     (strb_b),
        .rd_data   (rd_data),
        .bus_out   (bus_out),
        .oe_lo     (bus_oe_lo),
        .oe_hi     (bus_oe_hi)
    );

    AST_NO_WR_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !proto_m68) |-> $past(b_s)); // R3

endmodule

// File: tb/host_bus_if_test.sv
module host_bus_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        proto_m68 = 0;
    logic        wide_mode = 0;
    logic        cs_n = 1;
    logic        rs = 0;
    logic        strb_a = 1;
    logic        strb_b = 1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe_lo, bus_oe_hi;
    logic        wr_valid, wr_cmd;
    logic [15:0] wr_data;
    logic [15:0] rd_data = '0;
    logic        rd_done, rd_cmd;

    int checks = 0;
    int failures = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    logic [16:0] wr_q[$];
    logic        rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_bus_if #(.LANE_W(8), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .proto_m68(proto_m68), .wide_mode(wide_mode),
        .cs_n(cs_n), .rs(rs), .strb_a(strb_a), .strb_b(strb_b),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe_lo(bus_oe_lo),
        .bus_oe_hi(bus_oe_hi), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .rd_data(rd_data), .rd_done(rd_done), .rd_cmd(rd_cmd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces results
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                wr_seen++;
                if (wr_q.size() == 0) begin
                    check(0, "R3/R4 unexpected write", {15'd0, wr_cmd, wr_data}, 0);
                end else begin
                    logic [16:0] e;
                    e = wr_q.pop_front();
                    check({wr_cmd, wr_data} == e, "R6/R7/R8 write item",
                          {15'd0, wr_cmd, wr_data}, {15'd0, e});
                end
            end
            if (rd_done) begin
                rd_seen++;
                if (rd_q.size() == 0) begin
                    check(0, "R9 unexpected read done", rd_cmd, 0);
                end else begin
                    logic e;
                    e = rd_q.pop_front();
                    check(rd_cmd == e, "R9 read tag", rd_cmd, e);
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        if (proto_m68) begin strb_a = 0; strb_b = 1; end
        else           begin strb_a = 1; strb_b = 1; end
    endtask

    task automatic do_reset(input logic m68);
        @(negedge clk);
        rst_n = 0;
        cs_n = 1;
        proto_m68 = m68;
        idle_pins();
        cycles(4);
        rst_n = 1;
        cycles(4);
    endtask

    task automatic open_write();
        if (proto_m68) begin strb_b = 0; cycles(1); strb_a = 1; end
        else           strb_b = 0;
    endtask

    task automatic close_write();
        if (proto_m68) strb_a = 0;
        else           strb_b = 1;
    endtask

    // host write with scoreboard push
    task automatic host_write(input logic tag, input logic [15:0] d, input bit expect_it);
        logic [15:0] e;
        e = wide_mode ? d : {8'h00, d[7:0]};
        rs = tag; bus_in = d;
        cs_n = 0;
        cycles(2);
        open_write();
        cycles(4);
        if (expect_it) wr_q.push_back({tag, e});
        close_write();
        cycles(SYNC + 1);
        check(wr_valid == 1'b1, "R12 write request timing", wr_valid, 1);
        cycles(1);
        check(wr_valid == 1'b0, "R12 single-cycle request", wr_valid, 0);
        cs_n = 1;
        idle_pins();
        cycles(4);
    endtask

    task automatic host_read(input logic tag, input logic [15:0] d, input string req);
        rs = tag; rd_data = d;
        cs_n = 0;
        cycles(2);
        if (proto_m68) begin strb_b = 1; strb_a = 1; end
        else           strb_a = 0;
        #1;
        check(bus_oe_lo == 1'b1, req, bus_oe_lo, 1);
        check(bus_oe_hi == wide_mode, wide_mode ? "R7 upper lane enable" : "R8 upper lane off",
              bus_oe_hi, wide_mode);
        if (wide_mode) check(bus_out == d, "R7 read data 16", bus_out, d);
        else           check(bus_out[7:0] == d[7:0], "R8 read data 8", bus_out[7:0], d[7:0]);
        cycles(4);
        rd_q.push_back(tag);
        if (proto_m68) strb_a = 0;
        else           strb_a = 1;
        #1;
        check(bus_oe_lo == 1'b0, req, bus_oe_lo, 0);
        cycles(SYNC + 3);
        cs_n = 1;
        idle_pins();
        cycles(4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int seen;
        cycles(3);
        check(wr_valid == 0 && rd_done == 0, "R11 reset pulses", {wr_valid, rd_done}, 0);
        check(bus_oe_lo == 0 && bus_oe_hi == 0, "R11 reset oe", {bus_oe_lo, bus_oe_hi}, 0);
        do_reset(1'b0);
        check(wr_valid == 0 && bus_oe_lo == 0, "R11 after reset", {wr_valid, bus_oe_lo}, 0);

        // strobe-pair mode, narrow
        wide_mode = 0;
        host_write(1'b1, 16'h003C, 1);                    // R3 R6 command
        host_write(1'b0, 16'hA55A, 1);                    // R8 upper lanes dropped
        host_read(1'b1, 16'h12C3, "R1 read oe");

        // R5: write strobe with chip select high
        seen = wr_seen;
        rs = 1; bus_in = 16'h0077; strb_b = 0; strb_a = 0;
        #1 check(bus_oe_lo == 0, "R5 oe with cs high", bus_oe_lo, 0);
        cycles(4); strb_b = 1; strb_a = 1; cycles(8);
        check(wr_seen == seen, "R5 no write with cs high", wr_seen, seen);

        // R5: chip select released before the strobe
        cs_n = 0; cycles(2); strb_b = 0; cycles(4);
        cs_n = 1; cycles(4); strb_b = 1; cycles(8);
        check(wr_seen == seen, "R5 early cs release", wr_seen, seen);

        // strobe-pair mode, wide
        wide_mode = 1;
        cycles(2);
        host_write(1'b0, 16'hBEEF, 1);                    // R7
        host_read(1'b0, 16'h7E81, "R1 read oe wide");

        // enable/direction mode
        do_reset(1'b1);
        wide_mode = 0;
        host_write(1'b1, 16'h5A96, 1);                    // R4 R6
        host_read(1'b0, 16'h00E4, "R2 read oe");

        // R10: direction flips to read while enable high
        seen = wr_seen;
        rs = 1; bus_in = 16'h0011; cs_n = 0; cycles(2);
        strb_b = 0; cycles(1); strb_a = 1; cycles(4);
        strb_b = 1;
        #1 check(bus_oe_lo == 1, "R2 oe on flip to read", bus_oe_lo, 1);
        rd_q.push_back(1'b1);
        cycles(4); strb_a = 0; cycles(8);
        check(wr_seen == seen, "R10 no write after flip", wr_seen, seen);
        cs_n = 1; cycles(4);

        // R5 in enable/direction mode
        strb_b = 1; strb_a = 1;
        #1 check(bus_oe_lo == 0, "R5 oe cs high m68", bus_oe_lo, 0);
        strb_a = 0; cycles(4);

        wide_mode = 1;
        cycles(2);
        host_write(1'b0, 16'hC0DE, 1);                    // R4 R7
        host_read(1'b1, 16'hF00D, "R2 read oe wide");

        cycles(10);
        check(wr_q.size() == 0, "R3/R4 missing writes", wr_q.size(), 0);
        check(rd_q.size() == 0, "R9 missing read done", rd_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule